// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single 16-bit down-counting channel for an interval timer. It advances only on cycles where the count-enable `tick` is high. A `gate` input either holds the count or retriggers it, depending on the mode. A separate bus interface supplies a load strobe, a 16-bit initial value and a 3-bit mode. The channel returns its live count for readback. It also drives a wave output that can serve as an interrupt request.

A load captures the mode and the initial value, and counting restarts from that value. A zero initial value behaves as 65536, because the register wraps. The six modes differ in three ways: how the gate acts, whether the count reloads by itself, and what shape the output takes. The shapes are a level at terminal count, a one-shot low pulse, a periodic one-tick strobe, a square wave, and single strobes started by software or by hardware. Codes 6 and 7 are aliases of codes 2 and 3. Counting is binary only.

Top module: `interval_counter`

## Requirements
- R1: On `load`, `count` takes `load_val` on the next cycle and counting restarts from it. In mode 3, bit 0 of the value is cleared. `load` takes priority over a gate edge and over `tick`.
- R2: A loaded value of 0 acts as 65536. The first counted tick yields 16'hFFFF.
- R3: Mode 0 (code 3'b000) sets `out` low on load. The count falls by 1 per tick. `out` goes high on the tick that brings the count to 0, and then stays high while the count wraps modulo 2^16.
- R4: Mode 1 (3'b001) keeps `out` high after a load. A gate rising edge reloads the initial value and drives `out` low. `out` returns high on the tick that reaches 0.
- R5: Mode 2 (3'b010) keeps `out` high after a load. The count falls by 1 per tick. When the count reaches 1, `out` is low for that one tick. The next tick reloads the initial value and sets `out` high again, so the period equals the initial value.
- R6: Mode 3 (3'b011) subtracts 2 per tick from an even count. On the tick taken while the count is 2, it reloads the even initial value and toggles `out`. `out` starts high after a load.
- R7: Mode 4 (3'b100) keeps `out` high and drives it low for exactly the one tick on which the count first reaches 0 after a load.
- R8: Mode 5 (3'b101) behaves like mode 4. The difference is that the single low pulse is armed by a gate rising edge, and that edge also reloads the initial value.
- R9: In modes 0, 2, 3 and 4, a low `gate` holds the count. In modes 1 and 5, the gate level does not affect counting.
- R10: In modes 1, 2, 3 and 5, a gate rising edge (gate high on this cycle, low on the previous one) restarts the count from the initial value.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: While `tick` is low and neither a load nor a gate edge occurs, `count` does not change.
- R13: After reset, `count` is 0 and `out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| gate | input | 1 | Gate level; a rising edge retriggers some modes |
| load | input | 1 | Strobe that captures `load_val` and `mode_in` |
| load_val | input | 16 | Initial count (0 means 65536) |
| mode_in | input | 3 | Counting mode, captured on `load` |
| count | output | 16 | Live count value |
| out | output | 1 | Channel wave output |

## Verification
Each mode is run from a fresh load for several tick counts that stop before, at and just after its terminal or reload point. This shows whether an edge is placed one tick early or late. Loads of 0 and odd values check the wrap and the rounding to an even value. Directed sequences place the gate rising edge before any tick, and drop the gate in the middle of a count. These separate the modes where the gate holds the count from those where it retriggers, and check that a one-shot pulse fires only once.

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode_in,
  output logic [W-1:0] count,
  output logic         out
);
  logic [2:0]   m_q;
  logic [W-1:0] init_q;
  logic         gate_q, armed;

  wire [2:0]   m_eff     = (mode_in[2:1] == 2'b11) ? {1'b0, mode_in[1:0]} : mode_in;
  wire [W-1:0] even_init = {init_q[W-1:1], 1'b0};
  wire [W-1:0] dec1      = count - W'(1);
  wire [W-1:0] dec2      = count - W'(2);
  wire         rise      = gate & ~gate_q;
  wire         gated     = (m_q == 3'd0) || (m_q == 3'd2) || (m_q == 3'd3) || (m_q == 3'd4);
  wire         retrig    = (m_q == 3'd1) || (m_q == 3'd2) || (m_q == 3'd3) || (m_q == 3'd5);
  wire         run       = tick & (gate | ~gated);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= 3'd0;
      init_q <= '0;
      count  <= '0;
      gate_q <= 1'b0;
      armed  <= 1'b0;
      out    <= 1'b1;
    end else begin
      gate_q <= gate;
      if (load) begin
        m_q    <= m_eff;
        init_q <= load_val;
        count  <= (m_eff == 3'd3) ? {load_val[W-1:1], 1'b0} : load_val;
        out    <= (m_eff != 3'd0);
        armed  <= (m_eff == 3'd0) || (m_eff == 3'd4);
      end else if (rise && retrig) begin
        count <= (m_q == 3'd3) ? even_init : init_q;
        out   <= (m_q != 3'd1);
        armed <= (m_q == 3'd1) || (m_q == 3'd5);
      end else if (run) begin
        case (m_q)
          3'd0, 3'd1: begin
            count <= dec1;
            if (armed && dec1 == '0) begin
              out   <= 1'b1;
              armed <= 1'b0;
            end
          end
          3'd4, 3'd5: begin
            count <= dec1;
            if (armed && dec1 == '0) begin
              out   <= 1'b0;
              armed <= 1'b0;
            end else begin
              out <= 1'b1;
            end
          end
          3'd2: begin
            if (count == W'(1)) begin
              count <= init_q;
              out   <= 1'b1;
            end else begin
              count <= dec1;
              out   <= (dec1 != W'(1));
            end
          end
          3'd3: begin
            if (count == W'(2)) begin
              count <= even_init;
              out   <= ~out;
            end else begin
              count <= dec2;
            end
          end
          default: count <= dec1;
        endcase
      end
    end
  end
endmodule

module interval_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         gate,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [2:0]   mode_in,
  input logic [W-1:0] count,
  input logic         out,
  input logic [2:0]   m_q
);
  a_r1_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode_in[1:0] != 2'b11 |=> count == $past(load_val));

  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !tick && !gate |=> $stable(count));

  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q == 3'd0 || m_q == 3'd4) && tick && !gate && !load |=> $stable(count));

  a_r6_even_count: assert property (@(posedge clk) disable iff (!rst_n)
    m_q == 3'd3 |-> !count[0]);

  a_r3_load_low: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode_in == 3'd0 |=> !out);

  a_r5_load_high: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode_in == 3'd2 |=> out);
endmodule

bind interval_counter interval_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
  .load_val(load_val), .mode_in(mode_in), .count(count), .out(out), .m_q(m_q)
);

// File: tb/interval_counter_tb.sv
module interval_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, gate = 1'b0, load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_in = '0;
  logic [15:0] count;
  logic        out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  interval_counter u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .load_val(load_val), .mode_in(mode_in), .count(count), .out(out));

  // {req, mode, value, ticks, expected count, expected out}
  localparam int N = 18;
  localparam logic [47:0] VEC [N] = '{
    {4'd3,  3'd0, 16'd5,  8'd3, 16'd2,      1'b0},  // R3
    {4'd3,  3'd0, 16'd5,  8'd5, 16'd0,      1'b1},  // R3
    {4'd2,  3'd0, 16'd0,  8'd1, 16'hFFFF,   1'b0},  // R2
    {4'd3,  3'd0, 16'd3,  8'd4, 16'hFFFF,   1'b1},  // R3 wrap
    {4'd5,  3'd2, 16'd4,  8'd3, 16'd1,      1'b0},  // R5
    {4'd5,  3'd2, 16'd4,  8'd4, 16'd4,      1'b1},  // R5
    {4'd5,  3'd2, 16'd4,  8'd5, 16'd3,      1'b1},  // R5
    {4'd6,  3'd3, 16'd6,  8'd2, 16'd2,      1'b1},  // R6
    {4'd6,  3'd3, 16'd6,  8'd3, 16'd6,      1'b0},  // R6
    {4'd6,  3'd3, 16'd7,  8'd3, 16'd6,      1'b0},  // R6 odd
    {4'd6,  3'd3, 16'd6,  8'd6, 16'd6,      1'b1},  // R6
    {4'd7,  3'd4, 16'd3,  8'd3, 16'd0,      1'b0},  // R7
    {4'd7,  3'd4, 16'd3,  8'd4, 16'hFFFF,   1'b1},  // R7
    {4'd11, 3'd6, 16'd4,  8'd3, 16'd1,      1'b0},  // R11
    {4'd11, 3'd7, 16'd6,  8'd3, 16'd6,      1'b0},  // R11
    {4'd4,  3'd1, 16'd5,  8'd2, 16'd3,      1'b1},  // R4 no trigger
    {4'd8,  3'd5, 16'd4,  8'd2, 16'd2,      1'b1},  // R8 no trigger
    {4'd1,  3'd2, 16'd9,  8'd0, 16'd9,      1'b1}   // R1
  };

  task automatic check(input string req, input logic [15:0] ec, input logic eo);
    checks++;
    if (count !== ec || out !== eo) begin
      errors++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b", req, count, out, ec, eo);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    @(negedge clk); load = 1'b1; mode_in = m; load_val = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk); gate = g;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13", 16'd0, 1'b1);
    rst_n = 1'b1;
    set_gate(1'b1);
    for (int k = 0; k < N; k++) begin
      do_load(VEC[k][43:41], VEC[k][40:25]);
      ticks(int'(VEC[k][24:17]));
      check($sformatf("R%0d row %0d", VEC[k][47:44], k), VEC[k][16:1], VEC[k][0]);
    end

    // R12: clocks without tick leave the count alone
    do_load(3'd0, 16'd7); ticks(2);
    repeat (5) @(negedge clk);
    check("R12", 16'd5, 1'b0);

    // R1: a reload in the middle of a count restarts it
    do_load(3'd2, 16'd9); ticks(3);
    do_load(3'd2, 16'd20);
    check("R1", 16'd20, 1'b1);

    // R9: gate low holds modes 0 and 2
    do_load(3'd0, 16'd5); set_gate(1'b0); ticks(3);
    check("R9 mode0 hold", 16'd5, 1'b0);
    do_load(3'd2, 16'd5); ticks(2);
    check("R9 mode2 hold", 16'd5, 1'b1);

    // R10: gate rise restarts mode 2 and mode 3
    set_gate(1'b1); ticks(2);
    check("R10 mode2 run", 16'd3, 1'b1);
    set_gate(1'b0); set_gate(1'b1);
    check("R10 mode2 restart", 16'd5, 1'b1);
    do_load(3'd3, 16'd6); ticks(1);
    set_gate(1'b0); set_gate(1'b1);
    check("R10 mode3 restart", 16'd6, 1'b1);

    // R4: mode 1 one-shot
    set_gate(1'b0);
    do_load(3'd1, 16'd3);
    set_gate(1'b1);
    check("R4 trigger", 16'd3, 1'b0);
    ticks(2);
    check("R4 counting", 16'd1, 1'b0);
    ticks(1);
    check("R4 terminal", 16'd0, 1'b1);
    set_gate(1'b0); ticks(1);
    check("R9 mode1 ignores gate", 16'hFFFF, 1'b1);

    // R8: mode 5 hardware strobe
    do_load(3'd5, 16'd2);
    set_gate(1'b1);
    check("R8 trigger", 16'd2, 1'b1);
    ticks(1);
    check("R8 count1", 16'd1, 1'b1);
    ticks(1);
    check("R8 pulse", 16'd0, 1'b0);
    ticks(1);
    check("R8 pulse ends", 16'hFFFF, 1'b1);

    // R7: mode 4 pulse only once across a full wrap
    do_load(3'd4, 16'd1); ticks(1);
    check("R7 pulse", 16'd0, 1'b0);
    ticks(1);
    check("R7 after", 16'hFFFF, 1'b1);

    finish_run();
  end
endmodule